// File: doc/BRIEF.md
# Bus Cycle T-State Sequencer

This block runs single external bus transfers for a processor core. A transfer request names an address, a direction (read or write), a space (memory or I/O) and, for writes, the data. The sequencer steps each transfer through the clock states T1, T2, any number of wait states TW, T3 and T4. From those states it derives the address latch pulse, the active-low read, write and data-buffer enables, the direction line and the memory/I/O select. It captures the read data and reports completion in T4.

A slow memory or peripheral stretches a transfer by holding the bus-ready input low. The sequencer samples that input only at the end of T2 and at the end of every wait state. When no request is waiting, the sequencer fills the bus with one-clock idle states. A new request is accepted only while the bus is idle or in the closing T4 state, so transfers can run back to back with no idle state between them.

Top module: `bus_tstate_seq`

## Requirements
- R1: While rst_n is low, and in the first clock after it is released, tstate reads 0 (idle), ale is low, rd_n, wr_n and den_n are high, bus_wdata_oe and rsp_done are low, and req_ready is high.
- R2: req_ready is high exactly when tstate is idle (0) or T4 (5). A request accepted at a clock edge puts the sequencer in T1 (tstate 1) in the next clock, with ale high and bus_addr equal to the accepted address. req_valid has no effect while req_ready is low.
- R3: From T1 the sequencer always moves to T2 (tstate 2). In T2, every wait state (tstate 3) and T3 (tstate 4), den_n is low, and rd_n is low for a read or wr_n is low for a write. The other strobe stays high. Both strobes and den_n are high in idle, T1 and T4.
- R4: For a write, bus_wdata_oe is high and bus_wdata equals the request data in T2, the wait states and T3. bus_wdata_oe is low in every other state and for reads.
- R5: bus_ready is sampled only at the end of T2 and at the end of each wait state. Low gives a wait state (tstate 3) next and high gives T3 next. Its value in idle, T1, T3 and T4 has no effect.
- R6: For a read, bus_rdata present at the end of T3 appears on rsp_rdata from T4 on. rsp_rdata holds that value until the next read's T3, whatever bus_rdata does afterwards.
- R7: rsp_done is high only in T4, which lasts one clock per transfer.
- R8: dt_r is high for a write and low for a read, and mem_sel is high for a memory request and low for an I/O request (req_io high). Both take the request's values from T1 on and hold them through T4 and any following idle states until the next acceptance.
- R9: A transfer with N wait states lasts 4 + N clocks from T1 through T4. A request accepted in T4 starts T1 in the very next clock.
- R10: With no request pending, the sequencer stays idle (tstate 0), one clock per idle state, with all strobes inactive and rsp_done low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request pending |
| req_ready | output | 1 | Request is accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | Transfer completes (T4) |
| rsp_rdata | output | DW | Captured read data |
| tstate | output | 3 | Current state: 0 idle, 1 T1, 2 T2, 3 TW, 4 T3, 5 T4 |
| bus_addr | output | AW | Address driven on the bus |
| ale | output | 1 | Address latch enable, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dt_r | output | 1 | Data direction: 1 transmit, 0 receive |
| mem_sel | output | 1 | 1 memory, 0 I/O |
| bus_wdata | output | DW | Write data driven to the bus |
| bus_wdata_oe | output | 1 | Write data output enable |
| bus_rdata | input | DW | Read data from the bus |
| bus_ready | input | 1 | Slave ready; low inserts wait states |

## Verification
The hardest situation to reach is a transfer whose bus_ready and bus_rdata inputs change in the states where they must be ignored: ready toggling in T1 and T3, and read data changing right after its capture. The case is harder still when a further request is either chained straight out of T4 or offered while the sequencer is busy. The stimulus drives random ready values in T1 and T3. It replaces bus_rdata with its complement in T4, and it optionally holds req_valid with a decoy address through T2 and T3. The random transfers draw their wait counts, directions and chaining at random, and directed cases cover zero waits, a long wait run and consecutive chained transfers.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_TW   = 3'd3,
        TS_T3   = 3'd4,
        TS_T4   = 3'd5
    } tstate_e;

    // States in which the data phase strobes are active
    function automatic logic in_data_phase(tstate_e s);
        return (s == TS_T2) || (s == TS_TW) || (s == TS_T3);
    endfunction

    // States in which a new request may be taken
    function automatic logic can_accept(tstate_e s);
        return (s == TS_IDLE) || (s == TS_T4);
    endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    bus_ready,
    output tstate_e state_o,
    output logic    accept_o
);

    typedef struct packed {
        tstate_e state;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        accept_o = can_accept(fsm_q.state) && req_valid;
        unique case (fsm_q.state)
            TS_IDLE: if (accept_o) fsm_d.state = TS_T1;
            TS_T1:   fsm_d.state = TS_T2;
            TS_T2:   fsm_d.state = bus_ready ? TS_T3 : TS_TW;
            TS_TW:   fsm_d.state = bus_ready ? TS_T3 : TS_TW;
            TS_T3:   fsm_d.state = TS_T4;
            TS_T4:   fsm_d.state = accept_o ? TS_T1 : TS_IDLE;
            default: fsm_d.state = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.state <= TS_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.state;

endmodule

// File: rtl/bcs_cmd.sv
module bcs_cmd
    import bcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tstate_e       state_i,
    input  logic          accept_i,
    input  logic          req_write,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] addr_o,
    output logic          write_o,
    output logic          io_o,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rdata_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          write;
        logic          io;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (accept_i) begin
            cmd_d.addr  = req_addr;
            cmd_d.write = req_write;
            cmd_d.io    = req_io;
            cmd_d.wdata = req_wdata;
        end
        // read data is taken at the close of T3 only
        if (state_i == TS_T3 && !cmd_q.write) begin
            cmd_d.rdata = bus_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign addr_o  = cmd_q.addr;
    assign write_o = cmd_q.write;
    assign io_o    = cmd_q.io;
    assign wdata_o = cmd_q.wdata;
    assign rdata_o = cmd_q.rdata;

endmodule

// File: rtl/bcs_strobe.sv
module bcs_strobe
    import bcs_pkg::*;
(
    input  tstate_e state_i,
    input  logic    write_i,
    input  logic    io_i,
    output logic    ale,
    output logic    rd_n,
    output logic    wr_n,
    output logic    den_n,
    output logic    dt_r,
    output logic    mem_sel,
    output logic    wdata_oe,
    output logic    done,
    output logic    ready
);

    logic data_phase;

    always_comb begin
        data_phase = in_data_phase(state_i);
        ale        = (state_i == TS_T1);
        rd_n       = !(data_phase && !write_i);
        wr_n       = !(data_phase && write_i);
        den_n      = !data_phase;
        wdata_oe   = data_phase && write_i;
        dt_r       = write_i;
        mem_sel    = !io_i;
        done       = (state_i == TS_T4);
        ready      = can_accept(state_i);
    end

endmodule

// File: rtl/bus_tstate_seq.sv
module bus_tstate_seq
    import bcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic [2:0]    tstate,
    output logic [AW-1:0] bus_addr,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          den_n,
    output logic          dt_r,
    output logic          mem_sel,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready
);

    tstate_e state_w;
    logic    accept_w;
    logic    write_w;
    logic    io_w;

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .state_o   (state_w),
        .accept_o  (accept_w)
    );

    bcs_cmd #(.AW(AW), .DW(DW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state_w),
        .accept_i  (accept_w),
        .req_write (req_write),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_rdata (bus_rdata),
        .addr_o    (bus_addr),
        .write_o   (write_w),
        .io_o      (io_w),
        .wdata_o   (bus_wdata),
        .rdata_o   (rsp_rdata)
    );

    bcs_strobe u_strobe (
        .state_i  (state_w),
        .write_i  (write_w),
        .io_i     (io_w),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .den_n    (den_n),
        .dt_r     (dt_r),
        .mem_sel  (mem_sel),
        .wdata_oe (bus_wdata_oe),
        .done     (rsp_done),
        .ready    (req_ready)
    );

    assign tstate = state_w;

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          rsp_done,
    input logic [DW-1:0] rsp_rdata,
    input logic [2:0]    tstate,
    input logic [AW-1:0] bus_addr,
    input logic          ale,
    input logic          rd_n,
    input logic          wr_n,
    input logic          den_n,
    input logic          dt_r,
    input logic          bus_wdata_oe,
    input logic [DW-1:0] bus_rdata,
    input logic          bus_ready
);

    // R2
    accept_starts_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (ale && tstate == 3'd1 && bus_addr == $past(req_addr)));

    // R3
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (tstate == 3'd2));

    // R3
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R4
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (bus_wdata_oe && !den_n && dt_r));

    // R5
    wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == 3'd2 || tstate == 3'd3) && !bus_ready) |=> (tstate == 3'd3));

    // R5
    wait_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == 3'd2 || tstate == 3'd3) && bus_ready) |=> (tstate == 3'd4));

    // R6
    read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd4 && !dt_r) |=> (rsp_rdata == $past(bus_rdata)));

    // R7
    done_after_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd4) |=> rsp_done);

    // R10
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !req_valid) |=> (tstate == 3'd0 && rd_n && wr_n && den_n));

endmodule

bind bus_tstate_seq bcs_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .rsp_done     (rsp_done),
    .rsp_rdata    (rsp_rdata),
    .tstate       (tstate),
    .bus_addr     (bus_addr),
    .ale          (ale),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .den_n        (den_n),
    .dt_r         (dt_r),
    .bus_wdata_oe (bus_wdata_oe),
    .bus_rdata    (bus_rdata),
    .bus_ready    (bus_ready)
);

// File: tb/bus_tstate_seq_bench.sv
module bus_tstate_seq_bench;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic          req_write;
    logic          req_io;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [2:0]    tstate;
    logic [AW-1:0] bus_addr;
    logic          ale, rd_n, wr_n, den_n, dt_r, mem_sel;
    logic [DW-1:0] bus_wdata;
    logic          bus_wdata_oe;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit finished = 0;
    logic [DW-1:0] exp_rdata = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_tstate_seq #(.AW(AW), .DW(DW)) u_bus_tstate_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_io(req_io), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .tstate(tstate), .bus_addr(bus_addr), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .mem_sel(mem_sel),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // strobe pattern expected for a state of a transfer
    task automatic check_strobes(input string req, input bit wr, input bit data_phase);
        check(req, "rd_n", rd_n, !(data_phase && !wr));
        check(req, "wr_n", wr_n, !(data_phase && wr));
        check(req, "den_n", den_n, !data_phase);
        check("R4", "bus_wdata_oe", bus_wdata_oe, data_phase && wr);
    endtask

    task automatic check_idle();
        check("R10", "tstate idle", tstate, 0);
        check("R10", "rsp_done idle", rsp_done, 0);
        check("R10", "ale idle", ale, 0);
        check_strobes("R10", 1'b0, 1'b0);
        check("R2", "req_ready idle", req_ready, 1);
        check("R6", "rsp_rdata held", rsp_rdata, exp_rdata);
    endtask

    // Called just after a negedge with tstate idle or T4; returns at the T4 negedge.
    task automatic xfer(input bit wr, input bit io, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int nw,
                        input logic [DW-1:0] rd, input bit poke);
        int t1c;
        check("R2", "req_ready before accept", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_io = io; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        t1c = cyc;
        check("R2", "tstate T1", tstate, 1);
        check("R2", "ale in T1", ale, 1);
        check("R2", "bus_addr", bus_addr, a);
        check("R8", "dt_r in T1", dt_r, wr);
        check("R8", "mem_sel in T1", mem_sel, !io);
        check_strobes("R3", wr, 1'b0);
        bus_ready = 1'($urandom % 2);   // ignored in T1
        @(negedge clk);
        check("R3", "tstate T2", tstate, 2);
        check("R3", "ale after T1", ale, 0);
        check_strobes("R3", wr, 1'b1);
        if (wr) check("R4", "bus_wdata", bus_wdata, wd);
        check("R2", "req_ready busy", req_ready, 0);
        if (poke) begin
            req_valid = 1'b1; req_addr = a ^ 20'h5a5a5; req_write = !wr;
        end
        bus_ready = (nw == 0);
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            check("R5", "tstate TW", tstate, 3);
            check_strobes("R3", wr, 1'b1);
            check("R2", "req_ready in TW", req_ready, 0);
            bus_ready = (i == nw - 1);
        end
        @(negedge clk);
        check("R5", "tstate T3", tstate, 4);
        check_strobes("R3", wr, 1'b1);
        if (wr) check("R4", "bus_wdata T3", bus_wdata, wd);
        check("R2", "bus_addr held", bus_addr, a);
        bus_rdata = rd;
        bus_ready = 1'($urandom % 2);   // ignored in T3
        req_valid = 1'b0;
        @(negedge clk);
        check("R7", "tstate T4", tstate, 5);
        check("R7", "rsp_done T4", rsp_done, 1);
        check("R9", "cycle length", cyc - t1c + 1, 4 + nw);
        check_strobes("R3", wr, 1'b0);
        check("R8", "dt_r in T4", dt_r, wr);
        check("R8", "mem_sel in T4", mem_sel, !io);
        check("R2", "req_ready T4", req_ready, 1);
        if (!wr) exp_rdata = rd;
        check("R6", "rsp_rdata", rsp_rdata, exp_rdata);
        bus_rdata = ~rd;                // change after capture, must be ignored
        bus_ready = 1'($urandom % 2);
    endtask

    task automatic idle_step(input bit wr, input bit io);
        @(negedge clk);
        check_idle();
        check("R8", "dt_r held idle", dt_r, wr);
        check("R8", "mem_sel held idle", mem_sel, !io);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0;
        req_addr = '0; req_wdata = '0; bus_rdata = '0; bus_ready = 1'b1;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        check("R1", "tstate reset", tstate, 0);
        check("R1", "ale reset", ale, 0);
        check("R1", "rd_n reset", rd_n, 1);
        check("R1", "wr_n reset", wr_n, 1);
        check("R1", "den_n reset", den_n, 1);
        check("R1", "oe reset", bus_wdata_oe, 0);
        check("R1", "done reset", rsp_done, 0);
        check("R1", "req_ready reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "tstate after reset", tstate, 0);
        check_idle();

        // directed corner cases
        xfer(1'b0, 1'b0, 20'h12345, 16'h0000, 0, 16'hbeef, 1'b0); idle_step(1'b0, 1'b0);
        xfer(1'b1, 1'b0, 20'h00010, 16'hcafe, 0, 16'h0000, 1'b0); idle_step(1'b1, 1'b0);
        xfer(1'b0, 1'b1, 20'h003f8, 16'h0000, 3, 16'h1234, 1'b0); idle_step(1'b0, 1'b1);
        xfer(1'b1, 1'b1, 20'h00060, 16'h00a5, 2, 16'h0000, 1'b1); idle_step(1'b1, 1'b1);
        idle_step(1'b1, 1'b1);
        xfer(1'b0, 1'b0, 20'hfffff, 16'h0000, 20, 16'h8001, 1'b1); idle_step(1'b0, 1'b0);
        // back to back: chained out of T4
        xfer(1'b1, 1'b0, 20'h0abcd, 16'h7777, 0, 16'h0000, 1'b0);
        xfer(1'b0, 1'b0, 20'h0abce, 16'h0000, 1, 16'h4242, 1'b0);
        xfer(1'b0, 1'b1, 20'h00002, 16'h0000, 0, 16'h9999, 1'b0);
        idle_step(1'b0, 1'b1);

        // constrained random transfers
        for (int n = 0; n < 60; n++) begin
            bit wr, io, chain, poke;
            wr    = 1'($urandom % 2);
            io    = 1'($urandom % 4 == 0);
            chain = 1'($urandom % 2);
            poke  = 1'($urandom % 4 == 0);
            xfer(wr, io, AW'($urandom), DW'($urandom), int'($urandom % 5),
                 DW'($urandom), poke);
            if (!chain) idle_step(wr, io);
        end
        @(negedge clk);
        check_idle();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule